// File: doc/BRIEF.md
# Taken-Branch Target Line Cache

This block is a small, fully associative store of instruction lines captured at the targets of taken branches. When decode works out a branch target and predicts the branch taken, it presents that target address here. On a hit the block returns the whole stored line of instruction bytes in the same cycle, so the fetch stage can feed decode from this store while the main instruction cache fetch for the target is still under way. Each cycle, the fetch stage picks either this line or the instruction cache's line as its source.

Each entry holds instruction bytes and not a target address. The key is the full target address kept as a tag with a valid bit. After a miss, the line that the instruction cache returns is written in through a fill port. A fill to an address that is already present rewrites that entry in place. A fill to a new address takes the entry chosen by a round-robin victim pointer. A single-cycle invalidate input empties the whole store.

Top module: `tgt_line_cache`

## Requirements
- R1: After reset no entry is valid, the victim pointer is 0, and every lookup misses until a fill has been made.
- R2: When `lkp_req` is 1 and a valid entry's tag equals `lkp_addr`, `lkp_hit` is 1 in that same cycle and `lkp_line` carries that entry's stored bytes.
- R3: When no valid entry's tag equals `lkp_addr`, `lkp_hit` is 0 and `lkp_line` is all zeros.
- R4: A fill (`fil_req`=1) whose address matches no valid tag writes the entry at the victim pointer at the clock edge. The pointer then advances by one, wrapping from ENTRIES-1 to 0. The new line can be looked up from the next cycle.
- R5: A fill whose address equals a valid tag overwrites only that entry's bytes. It leaves the victim pointer unchanged and never makes a second copy of the tag.
- R6: Once ENTRIES distinct addresses have been filled, the next fill of a new address evicts the oldest-allocated entry, which then misses.
- R7: `inv_all`=1 clears every valid bit at the clock edge and returns the victim pointer to 0, so all lookups miss from the next cycle.
- R8: When `inv_all` and `fil_req` are both 1 in one cycle, the invalidate takes priority and the fill is discarded.
- R9: When a lookup and a fill name the same address in the same cycle, the lookup reports a miss in that cycle. The fill still completes, and the address hits from the next cycle.
- R10: When `lkp_req` is 0, `lkp_hit` is 0 and `lkp_line` is all zeros, whatever the state of the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_req | input | 1 | A lookup is presented this cycle |
| lkp_addr | input | ADDR_W | Computed branch target address used as the key |
| lkp_hit | output | 1 | A valid entry matches the key this cycle |
| lkp_line | output | LINE_BYTES*8 | Stored instruction bytes on a hit, zero otherwise |
| fil_req | input | 1 | Write a line returned by the instruction cache |
| fil_addr | input | ADDR_W | Target address the fill line belongs to |
| fil_line | input | LINE_BYTES*8 | Instruction bytes to store |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The bench builds the cache with ENTRIES=4, ADDR_W=12 and 16-byte lines. Four entries let the victim pointer wrap and evict after only a handful of fills. Drawing addresses from a pool of eight means random traffic keeps hitting, missing, rewriting in place and colliding with same-cycle fills. That brings the eviction order after in-place updates, invalidates in the middle of a stream, and same-address lookup-plus-fill cycles within reach of a few hundred cycles, with every one of them compared against a behavioural model.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  // What a fill does to the store in a given cycle.
  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_UPDATE = 2'd1,
    FILL_ALLOC  = 2'd2
  } fill_kind_e;

endpackage

// File: rtl/tlc_tag_bank.sv
module tlc_tag_bank #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ADDR_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0]  lk_tag,
  input  logic [ADDR_W-1:0]  fl_tag,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] fl_match
);

  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, valid_d;

  // Valid bits: the invalidate wins over a write in the same cycle (R7, R8).
  always_comb begin
    valid_d = valid_q;
    if (flush) begin
      valid_d = '0;
    end else if (wr_en) begin
      valid_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic tag_we;
    assign tag_we = wr_en && !flush && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (tag_we) tag_q[g] <= wr_tag;
    end

    assign lk_match[g] = valid_q[g] && (tag_q[g] == lk_tag);
    assign fl_match[g] = valid_q[g] && (tag_q[g] == fl_tag);
  end

  // R7: after an invalidate nothing is left valid.
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));

  // R4: a written entry is valid in the following cycle.
  a_r4_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> valid_q[$past(wr_idx)]);

  // R5: a tag is never held by two valid entries.
  a_r5_single_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match) && $onehot0(fl_match));

endmodule

// File: rtl/tlc_line_bank.sv
module tlc_line_bank #(
  parameter int ENTRIES = 16,
  parameter int LINE_W  = 128,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [LINE_W-1:0]  wr_line,
  input  logic [ENTRIES-1:0] rd_sel,
  output logic [LINE_W-1:0]  rd_line
);

  logic [LINE_W-1:0] line_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_line
    logic line_we;
    assign line_we = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (line_we) line_q[g] <= wr_line;
    end
  end

  // AND-OR read: the select is one-hot or empty, so an empty select gives zeros.
  always_comb begin
    rd_line = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      rd_line = rd_line | (line_q[i] & {LINE_W{rd_sel[i]}});
    end
  end

endmodule

// File: rtl/tlc_repl_ptr.sv
module tlc_repl_ptr #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clear) begin
      ptr_d = '0;
    end else if (adv) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R4: the pointer steps by one and wraps after the last entry.
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clear) |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

  // R7: an invalidate sends the pointer back to entry 0.
  a_r7_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ptr_q == '0));

  // R5: without an allocation the pointer holds.
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clear) |=> $stable(ptr_q));

endmodule

// File: rtl/tgt_line_cache.sv
module tgt_line_cache
  import tlc_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int LINE_BYTES = 16,
  parameter int ADDR_W     = 32,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_req,
  input  logic [ADDR_W-1:0] lkp_addr,
  output logic              lkp_hit,
  output logic [LINE_W-1:0] lkp_line,
  input  logic              fil_req,
  input  logic [ADDR_W-1:0] fil_addr,
  input  logic [LINE_W-1:0] fil_line,
  input  logic              inv_all
);

  logic [ENTRIES-1:0] lk_match, fl_match;
  logic [IDX_W-1:0]   vic_idx, upd_idx, wr_idx;
  logic [LINE_W-1:0]  rd_line;
  fill_kind_e         fill_kind;
  logic               wr_en, collide, any_lk;

  // Decide whether a fill updates in place (R5), allocates (R4) or is dropped (R8).
  always_comb begin
    if (!fil_req || inv_all) fill_kind = FILL_NONE;
    else if (|fl_match)      fill_kind = FILL_UPDATE;
    else                     fill_kind = FILL_ALLOC;
  end

  always_comb begin
    upd_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fl_match[i]) upd_idx = upd_idx | IDX_W'(i);
    end
  end

  assign wr_en  = (fill_kind != FILL_NONE);
  assign wr_idx = (fill_kind == FILL_UPDATE) ? upd_idx : vic_idx;

  tlc_tag_bank #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (inv_all),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (fil_addr),
    .lk_tag   (lkp_addr),
    .fl_tag   (fil_addr),
    .lk_match (lk_match),
    .fl_match (fl_match)
  );

  tlc_line_bank #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_lines (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_line (fil_line),
    .rd_sel  (lk_match),
    .rd_line (rd_line)
  );

  tlc_repl_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (inv_all),
    .adv   (fill_kind == FILL_ALLOC),
    .ptr   (vic_idx)
  );

  // R9: a fill for the same address this cycle forces a miss.
  assign collide  = fil_req && (fil_addr == lkp_addr);
  assign any_lk   = |lk_match;
  assign lkp_hit  = lkp_req && any_lk && !collide;
  assign lkp_line = lkp_hit ? rd_line : '0;

  a_r9_collide_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_req && fil_req && (lkp_addr == fil_addr)) |-> !lkp_hit);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_req |-> (!lkp_hit && (lkp_line == '0)));

  // R9 / R4: a completed fill is found by a lookup of that address next cycle.
  a_r9_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (fil_req && !inv_all) |=> (lkp_req && (lkp_addr == $past(fil_addr)) && !fil_req) |-> lkp_hit);

  a_r7_miss_after_inv: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lkp_hit);

endmodule

// File: tb/tb_tgt_line_cache.sv
module tb_tgt_line_cache;

  localparam int N    = 4;
  localparam int AW   = 12;
  localparam int LB   = 16;
  localparam int LW   = LB * 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lkp_req, fil_req, inv_all;
  logic [AW-1:0] lkp_addr, fil_addr;
  logic [LW-1:0] fil_line, lkp_line;
  logic          lkp_hit;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // Behavioural reference state.
  logic [AW-1:0] m_tag  [N];
  logic [LW-1:0] m_line [N];
  bit            m_v    [N];
  int            m_ptr;

  always #5 clk = ~clk;

  tgt_line_cache #(.ENTRIES(N), .LINE_BYTES(LB), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .lkp_req(lkp_req), .lkp_addr(lkp_addr), .lkp_hit(lkp_hit), .lkp_line(lkp_line),
    .fil_req(fil_req), .fil_addr(fil_addr), .fil_line(fil_line), .inv_all(inv_all)
  );

  function automatic logic [LW-1:0] rnd_line();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(string req, logic exp_hit, logic [LW-1:0] exp_line);
    n_vec++;
    if (lkp_hit !== exp_hit || lkp_line !== exp_line) begin
      n_bad++;
      $display("FAIL %s: hit=%0b line=%h expected hit=%0b line=%h",
               req, lkp_hit, lkp_line, exp_hit, exp_line);
    end
  endtask

  // One cycle: drive at the falling edge, compare before the rising edge,
  // then advance the model with the same stimulus.
  task automatic cyc(string req, logic lv, logic [AW-1:0] la,
                     logic fv, logic [AW-1:0] fa, logic [LW-1:0] fd, logic fl);
    logic          eh;
    logic [LW-1:0] el;
    int            hit_at;
    lkp_req = lv; lkp_addr = la; fil_req = fv; fil_addr = fa; fil_line = fd; inv_all = fl;
    #2;
    eh = 1'b0; el = '0;
    if (lv && !(fv && fa == la)) begin
      for (int j = 0; j < N; j++) begin
        if (m_v[j] && m_tag[j] == la) begin eh = 1'b1; el = m_line[j]; end
      end
    end
    check(req, eh, el);
    @(posedge clk);
    if (fl) begin
      for (int j = 0; j < N; j++) m_v[j] = 0;
      m_ptr = 0;
    end else if (fv) begin
      hit_at = -1;
      for (int j = 0; j < N; j++) if (m_v[j] && m_tag[j] == fa) hit_at = j;
      if (hit_at >= 0) m_line[hit_at] = fd;
      else begin
        m_tag[m_ptr] = fa; m_line[m_ptr] = fd; m_v[m_ptr] = 1;
        m_ptr = (m_ptr + 1) % N;
      end
    end
    @(negedge clk);
  endtask

  task automatic look(string req, logic [AW-1:0] a);
    cyc(req, 1'b1, a, 1'b0, '0, '0, 1'b0);
  endtask

  task automatic fill(string req, logic [AW-1:0] a);
    cyc(req, 1'b0, '0, 1'b1, a, rnd_line(), 1'b0);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < N; j++) m_v[j] = 0;
    m_ptr = 0;
    rst_n = 1'b0;
    lkp_req = 1'b1; lkp_addr = 12'h010; fil_req = 1'b0; fil_addr = '0; fil_line = '0; inv_all = 1'b0;
    repeat (3) @(negedge clk);
    #2 check("R1", 1'b0, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty after reset.
    look("R1", 12'h010);
    look("R1", 12'h000);
    // R2 / R3: single fill then hit and miss.
    fill("R4", 12'h010);
    look("R2", 12'h010);
    look("R3", 12'h011);
    // R10: idle lookup on a stored address.
    cyc("R10", 1'b0, 12'h010, 1'b0, '0, '0, 1'b0);
    // R4 / R6: fill the rest, then evict the oldest.
    fill("R4", 12'h020);
    fill("R4", 12'h030);
    fill("R4", 12'h040);
    look("R2", 12'h040);
    // R5: rewrite in place; pointer must stay on the oldest entry.
    fill("R5", 12'h020);
    look("R5", 12'h020);
    fill("R6", 12'h050);
    look("R6", 12'h010);
    look("R6", 12'h030);
    look("R5", 12'h020);
    // R9: same-address lookup and fill.
    cyc("R9", 1'b1, 12'h060, 1'b1, 12'h060, rnd_line(), 1'b0);
    look("R9", 12'h060);
    cyc("R9", 1'b1, 12'h060, 1'b1, 12'h060, rnd_line(), 1'b0);
    look("R9", 12'h060);
    // R7: invalidate with a lookup in the same cycle, then all miss.
    cyc("R7", 1'b1, 12'h060, 1'b0, '0, '0, 1'b1);
    look("R7", 12'h060);
    look("R7", 12'h050);
    // R8: invalidate beats a fill.
    cyc("R8", 1'b0, '0, 1'b1, 12'h070, rnd_line(), 1'b1);
    look("R8", 12'h070);
    fill("R7", 12'h080);
    look("R7", 12'h080);

    // Mixed traffic over a small address pool (R2, R3, R4, R5, R6, R9).
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] la, fa;
      la = 12'h100 + 12'($urandom_range(0, 7));
      fa = 12'h100 + 12'($urandom_range(0, 7));
      cyc("R2", 1'($urandom_range(0, 3) != 0), la, 1'($urandom_range(0, 2) == 0), fa,
          rnd_line(), 1'($urandom_range(0, 39) == 0));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule